// File: doc/BRIEF.md
# Three-wire serial master with chip-select routing

This block is a bus-programmed master for a three-wire synchronous serial link: a serial clock, one data line out and one data line in, plus four active-low device selects. Software loads a 16-bit outgoing word and writes a control word. The control word packs the outgoing bit count, the incoming bit count, the target device index and a select-assert bit. A transfer first shifts out the requested number of bits from the top of the outgoing word, most significant bit first. It then shifts in the requested number of bits and leaves them right-aligned in the receive register.

A transfer starts in one of two ways. The first is a strobe bit in the control word. The second is an automatic start when the transmit register is written, if the automatic mode is enabled and either the select-toggle enable or the select-assert bit is set. Two status bits track the transfer. One shows transmit data pending and clears when the write phase completes. The other shows receive data ready and clears when the receive register is read. At the end of the write phase the block pulses a transmit interrupt, or a transmit DMA request instead. At the end of the read phase it pulses a receive interrupt.

The serial clock idles low. Outgoing data changes on the falling edge and incoming data is sampled on the rising edge. Each half period of the serial clock lasts a fixed number of system clocks.

Top module: `uwire_master`

## Requirements
- R1: After reset, the control/status register (byte offset 0x04) and all five setup registers (offsets 0x08, 0x0C, 0x10, 0x14, 0x18) read as zero, every `cs_n` bit is 1 and `sclk` is 0.
- R2: A write to offset 0x04 stores only bits [12:0] and reads back with bits [15:13] at zero. The fields are: bits [4:0] read bit count, bits [9:5] write bit count, bits [11:10] device index, bit 12 select-assert, bit 13 start strobe (not stored), bit 14 transmit-pending flag, bit 15 receive-ready flag.
- R3: Each setup register stores the written value ANDed with its own mask and reads it back. The masks are 0x003F at 0x08, 0x0FC0 at 0x0C, 0x0003 at 0x10, 0x0001 at 0x14 and 0x000F at 0x18.
- R4: When the write bit count N is nonzero, a started transfer emits N bits on `sdo`, bit 15 of the transmit word first. The bits read on `sdo` at successive `sclk` rising edges therefore equal the transmit word shifted right by 16-N.
- R5: When the read bit count M is nonzero, M bits are sampled from `sdi` on the `sclk` rising edges after the write phase. They land right-aligned in the receive register (offset 0x00 on read), first bit highest, and bit 15 of the control/status register is set. A bus read of offset 0x00 returns the word and clears bit 15.
- R6: A write to offset 0x00 loads the transmit word and sets bit 14. Bit 14 clears when a write phase completes.
- R7: A write to offset 0x00 starts a transfer only when setup register 5 bit 2 is 1 and either setup register 5 bit 3 or control bit 12 is 1. Otherwise `sclk` stays still.
- R8: `cs_n[i]` is 0 exactly when control bit 12 is 1 and bits [11:10] equal i. At most one select is low at a time.
- R9: The end of the write phase gives a one-cycle pulse on `tx_irq` when setup register 5 bit 0 is 0, or on `tx_dma_req` when it is 1, never both. The end of the read phase gives a one-cycle pulse on `rx_irq`.
- R10: A start request that arrives while a transfer is in progress is ignored. The running transfer completes unchanged and no extra transfer follows.
- R11: A start with both bit counts zero produces no `sclk` edge and no interrupt or DMA pulse.
- R12: `sclk` is low whenever no transfer is active. Its period during a transfer is 2*DIV_HALF system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe; a read of offset 0x00 clears the ready flag |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the offset on `reg_addr` (combinational) |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data out, changes on the falling edge |
| sdi | input | 1 | Serial data in, sampled on the rising edge |
| cs_n | output | 4 | Active-low device selects |
| tx_irq | output | 1 | Write-phase-done interrupt pulse |
| rx_irq | output | 1 | Read-phase-done interrupt pulse |
| tx_dma_req | output | 1 | Write-phase-done DMA request pulse |

## Verification
A wrong bit counter or shift register shows up at the ports within one serial bit period: the device model sees the wrong number of `sclk` rising edges, or a word that differs from the top-N slice of the transmit word. A start that slips through while a transfer runs is just as visible, because a second pulse on `tx_irq` or `tx_dma_req` arrives with nothing in the scoreboard to match it. Flag bookkeeping errors are caught by reading the control/status register back within a few cycles of the triggering access or phase end. These errors are a busy bit that does not clear, a ready bit that a receive-register read does not clear, and an automatic start taken under the wrong setup bits.

// File: rtl/uwire_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the three-wire serial master.
// Assumes a 16-bit register word and fixed control field positions,
// since software decodes them.
package uwire_pkg;
    localparam int WORD_W   = 16;
    localparam int CNT_W    = 5;
    localparam int CS_COUNT = 4;
    localparam int IDX_W    = $clog2(CS_COUNT);
    localparam int N_SETUP  = 5;

    // control/status field positions
    localparam int F_RD_LO  = 0;
    localparam int F_WR_LO  = 5;
    localparam int F_IDX_LO = 10;
    localparam int F_SEL    = 12;
    localparam int F_GO     = 13;
    localparam int F_BUSY   = 14;
    localparam int F_RDY    = 15;

    // setup register 5 bits
    localparam int S5_DMA   = 0;
    localparam int S5_AUTO  = 2;
    localparam int S5_TOG   = 3;

    typedef enum logic [1:0] {PH_IDLE, PH_WRITE, PH_READ} phase_t;

    typedef struct packed {
        logic [CNT_W-1:0]  nwr;
        logic [CNT_W-1:0]  nrd;
        logic [WORD_W-1:0] word;
    } xfer_cfg_t;

    function automatic logic [WORD_W-1:0] setup_mask(input int idx);
        case (idx)
            0:       return 16'h003F;
            1:       return 16'h0FC0;
            2:       return 16'h0003;
            3:       return 16'h0001;
            default: return 16'h000F;
        endcase
    endfunction
endpackage

// File: rtl/uwire_regs.sv
`timescale 1ns/1ps
// Register file: transmit/receive words, control/status and setup registers.
// Produces the start request and the transfer configuration that the
// shifter captures. Assumes single-cycle bus strobes and word-aligned offsets.
module uwire_regs
    import uwire_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [4:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              tx_done,
    input  logic              rx_done,
    input  logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [3:0]        setup5,
    output logic              start,
    output xfer_cfg_t         cfg
);
    logic [2:0]        widx;
    logic [WORD_W-1:0] txbuf_q;
    logic [WORD_W-1:0] rxbuf_q;
    logic [WORD_W-1:0] setup_q [N_SETUP];
    logic              tdr_wr, csr_wr, rdr_rd;

    assign widx   = reg_addr[4:2];
    assign tdr_wr = reg_wr && (widx == 3'd0);
    assign csr_wr = reg_wr && (widx == 3'd1);
    assign rdr_rd = reg_rd && (widx == 3'd0);
    assign setup5 = setup_q[N_SETUP-1][3:0];

    // Start request: explicit strobe, or automatic start on a transmit write.
    always_comb begin
        start = (csr_wr && reg_wdata[F_GO])
             || (tdr_wr && setup5[S5_AUTO] && (setup5[S5_TOG] || ctrl_q[F_SEL]));
    end

    // Configuration for the shifter: use the value being written when it applies.
    always_comb begin
        cfg.nwr  = csr_wr ? reg_wdata[F_WR_LO +: CNT_W] : ctrl_q[F_WR_LO +: CNT_W];
        cfg.nrd  = csr_wr ? reg_wdata[F_RD_LO +: CNT_W] : ctrl_q[F_RD_LO +: CNT_W];
        cfg.word = tdr_wr ? reg_wdata : txbuf_q;
    end

    // Control/status register with the pending and ready flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (csr_wr) begin
                ctrl_q <= {3'b000, reg_wdata[F_SEL:0]};
            end else begin
                if (tdr_wr) ctrl_q[F_BUSY] <= 1'b1;
                if (rdr_rd) ctrl_q[F_RDY]  <= 1'b0;
            end
            if (tx_done) ctrl_q[F_BUSY] <= 1'b0;
            if (rx_done) ctrl_q[F_RDY]  <= 1'b1;
        end
    end

    // Transmit and receive data words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txbuf_q <= '0;
            rxbuf_q <= '0;
        end else begin
            if (tdr_wr)  txbuf_q <= reg_wdata;
            if (rx_done) rxbuf_q <= rx_word;
        end
    end

    // Setup registers, each masked on write.
    for (genvar g = 0; g < N_SETUP; g++) begin : g_setup
        always_ff @(posedge clk) begin
            if (!rst_n)
                setup_q[g] <= '0;
            else if (reg_wr && (widx == 3'(g + 2)))
                setup_q[g] <= reg_wdata & setup_mask(g);
        end
    end

    // Read data selection by word offset.
    always_comb begin
        case (widx)
            3'd0:    reg_rdata = rxbuf_q;
            3'd1:    reg_rdata = ctrl_q;
            3'd2:    reg_rdata = setup_q[0];
            3'd3:    reg_rdata = setup_q[1];
            3'd4:    reg_rdata = setup_q[2];
            3'd5:    reg_rdata = setup_q[3];
            3'd6:    reg_rdata = setup_q[4];
            default: reg_rdata = '0;
        endcase
    end

    a_r5_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> ctrl_q[F_RDY]);
    a_r6_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !ctrl_q[F_BUSY]);
    a_r2_go_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr |=> !ctrl_q[F_GO]);
endmodule

// File: rtl/uwire_shifter.sv
`timescale 1ns/1ps
// Serial engine: a write phase of nwr bits MSB-first, then a read phase of
// nrd bits. The serial clock idles low, data changes on its falling edge and
// is sampled on its rising edge. Each half period is DIV_HALF system clocks.
// Start requests are taken only while idle.
module uwire_shifter
    import uwire_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xfer_cfg_t         cfg,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic              active,
    output logic              tx_done,
    output logic              rx_done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int DIV_W = $clog2(DIV_HALF + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);

    phase_t            phase;
    logic [DIV_W-1:0]  cnt;
    logic [CNT_W-1:0]  bitcnt;
    logic [CNT_W-1:0]  nrd_q;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] rxsh;

    assign active = (phase != PH_IDLE);
    assign sdo    = (phase == PH_WRITE) && shreg[WORD_W-1];

    // Phase sequencing, clock division, shifting and sampling.
    always_ff @(posedge clk) begin
        tx_done <= 1'b0;
        rx_done <= 1'b0;
        if (!rst_n) begin
            phase   <= PH_IDLE;
            sclk    <= 1'b0;
            cnt     <= '0;
            bitcnt  <= '0;
            nrd_q   <= '0;
            shreg   <= '0;
            rxsh    <= '0;
            rx_word <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        cnt   <= '0;
                        sclk  <= 1'b0;
                        nrd_q <= cfg.nrd;
                        rxsh  <= '0;
                        shreg <= cfg.word;
                        if (cfg.nwr != '0) begin
                            phase  <= PH_WRITE;
                            bitcnt <= cfg.nwr;
                        end else if (cfg.nrd != '0) begin
                            phase  <= PH_READ;
                            bitcnt <= cfg.nrd;
                        end
                    end
                end
                default: begin
                    if (cnt == DIV_LAST) begin
                        cnt  <= '0;
                        sclk <= ~sclk;
                        if (!sclk) begin
                            if (phase == PH_READ) rxsh <= {rxsh[WORD_W-2:0], sdi};
                        end else if (bitcnt == CNT_W'(1)) begin
                            if (phase == PH_WRITE) begin
                                tx_done <= 1'b1;
                                if (nrd_q != '0) begin
                                    phase  <= PH_READ;
                                    bitcnt <= nrd_q;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end else begin
                                rx_done <= 1'b1;
                                rx_word <= rxsh;
                                phase   <= PH_IDLE;
                            end
                        end else begin
                            bitcnt <= bitcnt - CNT_W'(1);
                            if (phase == PH_WRITE) shreg <= {shreg[WORD_W-2:0], 1'b0};
                        end
                    end else begin
                        cnt <= cnt + DIV_W'(1);
                    end
                end
            endcase
        end
    end

    a_r12_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sclk);
    a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (active && start) |=> $stable(nrd_q));
    a_r9_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && rx_done));
endmodule

// File: rtl/uwire_master.sv
`timescale 1ns/1ps
// Top of the three-wire serial master: the register file, the serial engine,
// select decoding and event routing. Assumes four device selects and a fixed
// clock division set by DIV_HALF.
module uwire_master
    import uwire_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [4:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    output logic          sclk,
    output logic          sdo,
    input  logic          sdi,
    output logic [3:0]    cs_n,
    output logic          tx_irq,
    output logic          rx_irq,
    output logic          tx_dma_req
);
    logic [WORD_W-1:0] ctrl_q;
    logic [3:0]        setup5;
    logic              start;
    xfer_cfg_t         cfg;
    logic              tx_done, rx_done, active;
    logic [WORD_W-1:0] rx_word;

    uwire_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .tx_done  (tx_done),
        .rx_done  (rx_done),
        .rx_word  (rx_word),
        .ctrl_q   (ctrl_q),
        .setup5   (setup5),
        .start    (start),
        .cfg      (cfg)
    );

    uwire_shifter #(.DIV_HALF(DIV_HALF)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .cfg    (cfg),
        .sdi    (sdi),
        .sclk   (sclk),
        .sdo    (sdo),
        .active (active),
        .tx_done(tx_done),
        .rx_done(rx_done),
        .rx_word(rx_word)
    );

    // Select decode: one line low only when select-assert is set.
    for (genvar g = 0; g < CS_COUNT; g++) begin : g_cs
        assign cs_n[g] = !(ctrl_q[F_SEL] && (ctrl_q[F_IDX_LO +: IDX_W] == IDX_W'(g)));
    end

    // Event routing: transmit completion goes to interrupt or DMA request.
    always_comb begin
        tx_irq     = tx_done && !setup5[S5_DMA];
        tx_dma_req = tx_done &&  setup5[S5_DMA];
        rx_irq     = rx_done;
    end

    a_r9_tx_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);
    a_r9_tx_one_route: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_irq && tx_dma_req));
    a_r8_cs_one_low: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    a_r9_rx_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);
endmodule

// File: tb/tb_uwire_master.sv
`timescale 1ns/1ps
module tb_uwire_master;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sclk, sdo;
    logic        sdi = 1'b0;
    logic [3:0]  cs_n;
    logic        tx_irq, rx_irq, tx_dma_req;

    int checks = 0, fails = 0;
    int cyc = 0;
    bit finished = 0;

    uwire_master #(.DIV_HALF(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs_n(cs_n),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_dma_req(tx_dma_req)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- device model on the serial side
    int          sl_nwr = 0, sl_nrd = 0, sl_cnt = 0;
    logic [15:0] sl_rpat = '0;
    logic [31:0] sl_cap = '0;
    int          rise_c [2];

    function automatic logic sdi_for(input int i);
        if (i >= sl_nwr && i < sl_nwr + sl_nrd) return sl_rpat[sl_nrd - 1 - (i - sl_nwr)];
        return 1'b0;
    endfunction

    task automatic arm_slave(input int nwr, input int nrd, input logic [15:0] rpat);
        sl_nwr = nwr; sl_nrd = nrd; sl_rpat = rpat; sl_cnt = 0; sl_cap = '0;
        sdi = sdi_for(0);
    endtask

    always @(posedge sclk) begin
        if (sl_cnt < sl_nwr) sl_cap = {sl_cap[30:0], sdo};
        if (sl_cnt < 2) rise_c[sl_cnt] = cyc;
        sl_cnt++;
        sdi = sdi_for(sl_cnt);
    end

    // ---------------- scoreboard: expected transmit events, bit 16 = DMA route
    logic [16:0] exp_q [$];
    int rx_seen = 0;

    always @(negedge clk) begin
        if (rst_n && (tx_irq || tx_dma_req)) begin
            if (exp_q.size() == 0) begin
                check(0, "R10 unexpected transmit event", 1, 0);
            end else begin
                logic [16:0] e;
                e = exp_q.pop_front();
                check(tx_dma_req == e[16], "R9 transmit route", int'(tx_dma_req), int'(e[16]));
                check(sl_cap[15:0] == e[15:0], "R4 shifted word", int'(sl_cap[15:0]), int'(e[15:0]));
            end
        end
        if (rst_n && rx_irq) rx_seen++;
    end

    // ---------------- bus tasks
    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] ctl(input int idx, input bit sel, input int nwr, input int nrd, input bit go);
        return 16'((go << 13) | (sel << 12) | (idx << 10) | (nwr << 5) | nrd);
    endfunction

    // Explicitly started transfer with checks on counts and received data.
    task automatic xfer(input string tag, input int idx, input int nwr, input int nrd,
                        input logic [15:0] word, input logic [15:0] rpat, input bit dma);
        logic [15:0] v;
        int rx0;
        bus_write(5'h00, word);
        arm_slave(nwr, nrd, rpat);
        if (nwr > 0) exp_q.push_back({dma, 16'(word >> (16 - nwr))});
        rx0 = rx_seen;
        bus_write(5'h04, ctl(idx, 1, nwr, nrd, 1));
        wait_cyc((nwr + nrd) * 2 * DIV + 8);
        check(sl_cnt == nwr + nrd, {tag, " R4 R5 rising edge count"}, sl_cnt, nwr + nrd);
        check(sclk == 1'b0, {tag, " R12 sclk idle after transfer"}, int'(sclk), 0);
        if (nrd > 0) begin
            check(rx_seen == rx0 + 1, {tag, " R9 rx_irq pulse count"}, rx_seen - rx0, 1);
            bus_read(5'h04, v);
            check(v[15] == 1'b1, {tag, " R5 ready flag set"}, int'(v[15]), 1);
            bus_read(5'h00, v);
            check(v == (nrd == 16 ? rpat : (rpat & 16'((1 << nrd) - 1))), {tag, " R5 received word"},
                  int'(v), int'(nrd == 16 ? rpat : (rpat & 16'((1 << nrd) - 1))));
            bus_read(5'h04, v);
            check(v[15] == 1'b0, {tag, " R5 ready cleared by read"}, int'(v[15]), 0);
        end
    endtask

    // ---------------- watchdog
    initial begin
        #(200000 * 5);
        if (!finished) begin
            check(0, "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- test sequence
    initial begin
        logic [15:0] v;
        int c0;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        bus_read(5'h04, v); check(v == 16'h0, "R1 control reset", v, 0);
        for (int i = 0; i < 5; i++) begin
            bus_read(5'(8 + 4 * i), v); check(v == 16'h0, "R1 setup reset", v, 0);
        end
        check(cs_n == 4'hF, "R1 selects idle", cs_n, 4'hF);
        check(sclk == 1'b0, "R1 sclk low", sclk, 0);

        // R2 stored bits and R8 select decode
        bus_write(5'h04, 16'h1FFF);
        bus_read(5'h04, v); check(v == 16'h1FFF, "R2 stores bits 12:0", v, 16'h1FFF);
        check(cs_n == 4'b0111, "R8 select 3 asserted", cs_n, 4'b0111);
        bus_write(5'h04, 16'h0800);
        check(cs_n == 4'hF, "R8 no select without bit 12", cs_n, 4'hF);
        bus_write(5'h04, 16'h1400);
        check(cs_n == 4'b1101, "R8 select 1 asserted", cs_n, 4'b1101);
        bus_write(5'h04, 16'hC000);
        bus_read(5'h04, v); check(v == 16'h0000, "R2 flag bits not writable", v, 0);

        // R3 setup masks
        for (int i = 0; i < 5; i++) begin
            logic [15:0] m;
            m = (i == 0) ? 16'h003F : (i == 1) ? 16'h0FC0 : (i == 2) ? 16'h0003 :
                (i == 3) ? 16'h0001 : 16'h000F;
            bus_write(5'(8 + 4 * i), 16'hFFFF);
            bus_read(5'(8 + 4 * i), v); check(v == m, "R3 setup mask", v, m);
            bus_write(5'(8 + 4 * i), 16'h0000);
        end

        // R4 write phase widths, R12 bit period
        xfer("w8", 0, 8, 0, 16'hA5C3, 16'h0, 0);
        check(rise_c[1] - rise_c[0] == 2 * DIV, "R12 sclk period", rise_c[1] - rise_c[0], 2 * DIV);
        xfer("w5", 2, 5, 0, 16'hA5C3, 16'h0, 0);
        xfer("w16", 1, 16, 0, 16'h8001, 16'h0, 0);

        // R5 read phase, with and without a preceding write phase
        xfer("w8r8", 0, 8, 8, 16'h3C00, 16'h005A, 0);
        xfer("r12", 3, 0, 12, 16'h0000, 16'h0ABC, 0);
        xfer("r16", 0, 0, 16, 16'h0000, 16'hF00F, 0);

        // R9 DMA route
        bus_write(5'h18, 16'h0001);
        xfer("dma", 0, 4, 0, 16'hB000, 16'h0, 1);
        bus_write(5'h18, 16'h0000);

        // R7 automatic start gating, R6 pending flag
        bus_write(5'h18, 16'h0004);
        bus_write(5'h04, ctl(0, 0, 8, 0, 0));
        arm_slave(0, 0, 16'h0);
        bus_write(5'h00, 16'h1234);
        wait_cyc(40);
        check(sl_cnt == 0, "R7 no auto start without toggle or select", sl_cnt, 0);
        bus_read(5'h04, v); check(v[14] == 1'b1, "R6 pending set by transmit write", v[14], 1);

        bus_write(5'h18, 16'h000C);
        arm_slave(8, 0, 16'h0);
        exp_q.push_back({1'b0, 16'h0091});
        bus_write(5'h00, 16'h9100);
        wait_cyc(3);
        bus_read(5'h04, v); check(v[14] == 1'b1, "R6 pending during write phase", v[14], 1);
        wait_cyc(40);
        check(sl_cnt == 8, "R7 auto start with toggle enable", sl_cnt, 8);
        bus_read(5'h04, v); check(v[14] == 1'b0, "R6 pending cleared at write end", v[14], 0);

        bus_write(5'h18, 16'h0004);
        bus_write(5'h04, ctl(0, 1, 8, 0, 0));
        arm_slave(8, 0, 16'h0);
        exp_q.push_back({1'b0, 16'h0077});
        bus_write(5'h00, 16'h7700);
        wait_cyc(45);
        check(sl_cnt == 8, "R7 auto start with select bit", sl_cnt, 8);
        bus_write(5'h18, 16'h0000);

        // R10 start during transfer ignored
        arm_slave(16, 0, 16'h0);
        bus_write(5'h00, 16'hC3A5);
        exp_q.push_back({1'b0, 16'hC3A5});
        bus_write(5'h04, ctl(0, 1, 16, 0, 1));
        wait_cyc(10);
        bus_write(5'h04, ctl(0, 1, 4, 0, 1));
        wait_cyc(16 * 2 * DIV + 20);
        check(sl_cnt == 16, "R10 second start ignored", sl_cnt, 16);

        // R11 zero counts
        c0 = rx_seen;
        arm_slave(0, 0, 16'h0);
        bus_write(5'h04, ctl(0, 1, 0, 0, 1));
        wait_cyc(30);
        check(sl_cnt == 0, "R11 no sclk edge", sl_cnt, 0);
        check(rx_seen == c0, "R11 no rx_irq", rx_seen - c0, 0);

        check(exp_q.size() == 0, "R9 all transmit events seen", exp_q.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule